// File: doc/BRIEF.md
# Serial-to-Parallel Converter with Bit Slip

This block gathers a one-bit serial stream, one bit on each rising clock edge, into a parallel word of `WORD_W` bits (4 by default). The serial bit comes from one of two inputs. A select line chooses between them, so a local loopback path can stand in for the line input during test. A single divide counter sets the word boundaries. It yields a strobe each word and a strobe each word pair, plus a square-wave version of each.

A cadence input chooses when the parallel output loads: once per word (every 4 clocks) or once per word pair (every 8 clocks). The serial input, delayed by exactly one word, is presented on a registered serial output. Two instances that share clock and reset, both in pair cadence, with the second fed from the first's serial output, form a 1:8 converter. The slip input may change at any time relative to the clock. Each pulse freezes the divide counter for one clock, which moves the word boundary one bit later. The synchronous reset zeroes the counter so that several instances start in step.

Top module: `bitslip_deser`

## Requirements
- R1: After a load, `word_q[i]` holds the bit sampled on the (i+1)-th of the last `WORD_W` sampling edges, so the earliest bit is on bit 0 and the latest is on bit `WORD_W-1`.
- R2: The sampled bit is `sin_a` when `sel` is 1 and `sin_b` when `sel` is 0.
- R3: Let the phase be the number of edges since reset on which the counter advanced, modulo 2·`WORD_W`. On an advancing edge where phase mod `WORD_W` equals `WORD_W-1`, `word_stb` is high for the following cycle. With `mode` 0, `word_q` loads on that same edge and is unchanged at every other edge.
- R4: With `mode` 1, `word_q` loads only on an advancing edge whose phase is 2·`WORD_W`-1. `pair_stb` is high for the cycle after that edge, and `word_q` holds steady for the 2·`WORD_W`-1 cycles in between. `pair_stb` never rises without `word_stb`.
- R5: After each edge, `word_sq` is high when the phase mod `WORD_W` is at least `WORD_W`/2, and `pair_sq` is high when the phase is at least `WORD_W`.
- R6: The slip input passes through a two-stage synchronizer and a rising-edge detector. If `slip` is 1 at edge e and 0 at edge e-1, the counter does not advance at edge e+2, and no load or strobe occurs there. Each further slip needs a new rising edge; a level held high for many clocks counts once. After a slip, a bit that would have landed on bit n lands on bit n-1.
- R7: While `rst` is high at an edge, every output is 0 after that edge. The first edge with `rst` low samples phase 0, and the first word appears after the `WORD_W`-th such edge.
- R8: After edge n, `ser_out` equals the bit sampled at edge n-`WORD_W`+1, or 0 if there was no such edge since reset.
- R9: When two instances in pair cadence are chained through `ser_out`, and neither has slipped since a common reset, `{first.word_q, second.word_q}` holds the last 2·`WORD_W` sampled bits of the first instance, with the earliest bit on bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sin_a | input | 1 | Serial input A (loopback path) |
| sin_b | input | 1 | Serial input B (line path) |
| sel | input | 1 | 1 selects `sin_a`, 0 selects `sin_b` |
| mode | input | 1 | 0: load every word; 1: load every word pair |
| slip | input | 1 | Asynchronous slip request; one slip per rising edge |
| word_q | output | WORD_W | Parallel word, earliest bit on bit 0 |
| ser_out | output | 1 | Serial input delayed by one word, for cascading |
| word_stb | output | 1 | One-cycle strobe once per word |
| pair_stb | output | 1 | One-cycle strobe once per word pair |
| word_sq | output | 1 | Square wave at the word rate |
| pair_sq | output | 1 | Square wave at the word-pair rate |

## Verification
The bench builds the block with its defaults, `WORD_W` of 4 and two synchronizer stages. At that size every one of the eight phases can be swept many times. Slip pulses are applied at offsets that cover all phases, in both cadences, and a long slip level is held to show that it counts once. A second instance is chained to the first to check the 8-bit result against the recorded bit history. Expected words, strobes and waves come from a phase count that the bench keeps from its own record of sampled bits and slip levels.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef enum logic {
    CAD_WORD = 1'b0,
    CAD_PAIR = 1'b1
  } cadence_e;
endpackage

// File: rtl/bsd_slip_detect.sv
module bsd_slip_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic slip_async,
  output logic slip_stb
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], slip_async};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= slip_async;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[SYNC_STAGES-1];
  end

  // one cycle per rising level after synchronization
  assign slip_stb = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/bsd_divider.sv
module bsd_divider #(
  parameter int WORD_W = 4,
  localparam int LOG_W = $clog2(WORD_W),
  localparam int CNT_W = $clog2(2 * WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  output logic [CNT_W-1:0] phase,
  output logic             word_end,
  output logic             pair_end,
  output logic             word_sq,
  output logic             pair_sq
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (!hold) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign phase    = cnt_q;
  assign word_end = (cnt_q[LOG_W-1:0] == {LOG_W{1'b1}}) && !hold;
  assign pair_end = (cnt_q == {CNT_W{1'b1}}) && !hold;
  assign word_sq  = cnt_q[LOG_W-1];
  assign pair_sq  = cnt_q[CNT_W-1];
endmodule

// File: rtl/bsd_capture.sv
module bsd_capture
  import bsd_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  cadence_e          cadence,
  input  logic              word_end,
  input  logic              pair_end,
  output logic [WORD_W-1:0] word_q,
  output logic              ser_out,
  output logic              word_stb,
  output logic              pair_stb
);
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] shift_d;
  logic              load;

  // newest bit enters at the top, so the oldest sits on bit 0
  assign shift_d = {ser_in, shift_q[WORD_W-1:1]};
  assign load    = (cadence == CAD_PAIR) ? pair_end : word_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q  <= '0;
      word_q   <= '0;
      word_stb <= 1'b0;
      pair_stb <= 1'b0;
    end else begin
      shift_q  <= shift_d;
      word_stb <= word_end;
      pair_stb <= pair_end;
      if (load) word_q <= shift_d;
    end
  end

  assign ser_out = shift_q[0];
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser
  import bsd_pkg::*;
#(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(2 * WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sin_a,
  input  logic              sin_b,
  input  logic              sel,
  input  logic              mode,
  input  logic              slip,
  output logic [WORD_W-1:0] word_q,
  output logic              ser_out,
  output logic              word_stb,
  output logic              pair_stb,
  output logic              word_sq,
  output logic              pair_sq
);
  logic             ser_bit;
  logic             slip_stb;
  logic [CNT_W-1:0] phase;
  logic             word_end;
  logic             pair_end;

  assign ser_bit = sel ? sin_a : sin_b;

  bsd_slip_detect #(.SYNC_STAGES(SYNC_STAGES)) u_slip (
    .clk        (clk),
    .rst        (rst),
    .slip_async (slip),
    .slip_stb   (slip_stb)
  );

  bsd_divider #(.WORD_W(WORD_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .hold     (slip_stb),
    .phase    (phase),
    .word_end (word_end),
    .pair_end (pair_end),
    .word_sq  (word_sq),
    .pair_sq  (pair_sq)
  );

  bsd_capture #(.WORD_W(WORD_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .ser_in   (ser_bit),
    .cadence  (cadence_e'(mode)),
    .word_end (word_end),
    .pair_end (pair_end),
    .word_q   (word_q),
    .ser_out  (ser_out),
    .word_stb (word_stb),
    .pair_stb (pair_stb)
  );
endmodule

// File: rtl/bitslip_deser_chk.sv
module bitslip_deser_chk #(
  parameter int WORD_W = 4,
  localparam int CNT_W = $clog2(2 * WORD_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              mode,
  input logic              slip_stb,
  input logic [CNT_W-1:0]  phase,
  input logic [WORD_W-1:0] word_q,
  input logic              word_stb,
  input logic              pair_stb
);
  // R6
  slip_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    slip_stb |=> $stable(phase));

  // R6
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    !slip_stb |=> (phase == $past(phase) + CNT_W'(1)));

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_stb |-> $stable(word_q));

  // R4
  pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) && !pair_stb) |-> $stable(word_q));

  // R4
  pair_in_word_chk: assert property (@(posedge clk) disable iff (rst)
    pair_stb |-> word_stb);
endmodule

bind bitslip_deser bitslip_deser_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .slip_stb (slip_stb),
  .phase    (phase),
  .word_q   (word_q),
  .word_stb (word_stb),
  .pair_stb (pair_stb)
);

// File: tb/bitslip_deser_bench.sv
module bitslip_deser_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int HMAX       = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sin_a = 1'b0, sin_b = 1'b0, sel = 1'b1, mode = 1'b0, slip = 1'b0;
  logic [W-1:0] word_q, word_q_b;
  logic ser_out, ser_out_b, word_stb, pair_stb, word_sq, pair_sq;
  logic word_stb_b, pair_stb_b, word_sq_b, pair_sq_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitslip_deser #(.WORD_W(W)) u_bitslip_deser (
    .clk(clk), .rst(rst), .sin_a(sin_a), .sin_b(sin_b), .sel(sel),
    .mode(mode), .slip(slip), .word_q(word_q), .ser_out(ser_out),
    .word_stb(word_stb), .pair_stb(pair_stb), .word_sq(word_sq), .pair_sq(pair_sq)
  );

  // second stage of the 1:8 chain
  bitslip_deser #(.WORD_W(W)) u_bitslip_deser_b (
    .clk(clk), .rst(rst), .sin_a(ser_out), .sin_b(1'b0), .sel(1'b1),
    .mode(1'b1), .slip(1'b0), .word_q(word_q_b), .ser_out(ser_out_b),
    .word_stb(word_stb_b), .pair_stb(pair_stb_b), .word_sq(word_sq_b), .pair_sq(pair_sq_b)
  );

  int   checks = 0;
  int   errors = 0;
  int   n = 0;
  int   adv = 0;
  int   nslip = 0;
  logic hist  [0:HMAX-1];
  logic shist [0:HMAX-1];
  logic [W-1:0] exp_q = '0;
  logic [15:0]  lfsr = 16'hACE1;
  bit   done = 1'b0;

  function automatic logic hb(int i);
    return (i < 0) ? 1'b0 : hist[i];
  endfunction

  function automatic logic sb(int i);
    return (i < 0) ? 1'b0 : shist[i];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s edge %0d actual %0h expected %0h", tag, n, act, exp);
    end
  endtask

  task automatic evaluate();
    bit hold, e_word, e_pair, e_load;
    int cval;
    logic [W-1:0] e_b;
    hold   = sb(n-2) && !sb(n-3);
    cval   = adv % (2*W);
    e_word = !hold && ((cval % W) == W-1);
    e_pair = !hold && (cval == 2*W-1);
    e_load = mode ? e_pair : e_word;
    if (hold) nslip++;
    else      adv++;
    if (e_load) for (int i = 0; i < W; i++) exp_q[i] = hb(n-W+1+i);
    chk(word_stb == e_word, "R3 R6 word strobe", int'(word_stb), int'(e_word));
    chk(pair_stb == e_pair, "R4 pair strobe", int'(pair_stb), int'(e_pair));
    chk(word_q == exp_q, "R1 R2 R4 word", int'(word_q), int'(exp_q));
    chk(ser_out == hb(n-W+1), "R8 serial out", int'(ser_out), int'(hb(n-W+1)));
    chk(word_sq == ((adv % W) >= W/2), "R5 word wave", int'(word_sq), int'((adv % W) >= W/2));
    chk(pair_sq == ((adv % (2*W)) >= W), "R5 pair wave", int'(pair_sq), int'((adv % (2*W)) >= W));
    if (n == W-1) chk(word_stb == 1'b1, "R7 first word", int'(word_stb), 1);
    if (e_pair && nslip == 0) begin
      for (int i = 0; i < W; i++) e_b[i] = hb(n-2*W+1+i);
      chk({word_q, word_q_b} == {exp_q, e_b}, "R9 cascade",
          int'({word_q, word_q_b}), int'({exp_q, e_b}));
    end
  endtask

  task automatic tick(input logic a, input logic b, input logic s);
    sin_a = a; sin_b = b; slip = s;
    @(posedge clk);
    if (!rst && n < HMAX) begin
      hist[n]  = sel ? a : b;
      shist[n] = s;
    end
    @(negedge clk);
    if (rst) begin
      chk({word_q, ser_out, word_stb, pair_stb, word_sq, pair_sq} == '0, "R7 reset",
          int'({word_q, ser_out, word_stb, pair_stb, word_sq, pair_sq}), 0);
    end else if (n < HMAX) begin
      evaluate();
      n++;
    end
  endtask

  task automatic rnd_tick(input logic s);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tick(lfsr[0], lfsr[5], s);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(1'b1, 1'b1, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    rst = 1'b0;
    n = 0; adv = 0; nslip = 0; exp_q = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // word cadence, both inputs
    sel = 1'b1; mode = 1'b0;
    for (int k = 0; k < 200; k++) rnd_tick(1'b0);
    sel = 1'b0;
    for (int k = 0; k < 200; k++) rnd_tick(1'b0);
    // pair cadence with the chained stage, select toggling
    mode = 1'b1;
    for (int k = 0; k < 300; k++) begin
      if (k % 37 == 0) sel = ~sel;
      rnd_tick(1'b0);
    end
    for (int k = 0; k < 24; k++) tick(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 24; k++) tick(k[0], ~k[0], 1'b0);
    // slips swept across all phases
    do_reset();
    mode = 1'b0; sel = 1'b1;
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 9 + p; k++) rnd_tick(1'b0);
      rnd_tick(1'b1);
      rnd_tick(1'b1);
      if (p == 8) mode = 1'b1;
    end
    for (int k = 0; k < 20; k++) rnd_tick(1'b0);
    // long level is one slip
    for (int k = 0; k < 30; k++) rnd_tick(1'b1);
    for (int k = 0; k < 20; k++) rnd_tick(1'b0);
    chk(nslip == 17, "R6 slip count model", nslip, 17);
    mode = 1'b0; sel = 1'b0;
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 5 + 3*p; k++) rnd_tick(1'b0);
      rnd_tick(1'b1);
      rnd_tick(1'b1);
      rnd_tick(1'b1);
    end
    for (int k = 0; k < 30; k++) rnd_tick(1'b0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule